// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves data on behalf of a requester without the processor touching each item. Software (or a setup path) loads a start address, an optional second address, a transfer count and a mode word while the channel is idle. The channel then waits for a request, raises a bus request, waits for a grant and runs bus cycles as master. Each transfer is either one bus cycle between a peripheral and memory, or two bus cycles (read at the source, then write at the destination) for memory-to-memory copies.

Four request policies decide how many transfers follow one request. In single mode each request yields one transfer. In demand mode transfers run back to back while the request stays high. In single-step mode the bus is handed back after every transfer, and a processor cycle must complete before the next transfer. In burst mode each request yields a programmed number of transfers. A one-clock end pulse marks the last transfer, after which the channel is disabled until it is loaded again.

The state machine has eight states: IDLE (disabled), ARMED (waiting for a request), BUSREQ (bus requested, waiting for grant), T1 (address phase), T2 and T3 (strobe phases, T3 stretched by a low ready), CPU (bus released in single-step mode, waiting for a processor cycle) and DONE (end pulse). Its transitions are: IDLE to ARMED on a load with nonzero count; ARMED to BUSREQ on a request; BUSREQ to T1 on grant; T1 to T2; T2 to T3; T3 to T1 (second half of a copy, a demand repeat or a burst repeat), to ARMED (single, demand with the request dropped, burst exhausted), to CPU (single-step), or to DONE (count exhausted); CPU to BUSREQ on a processor-done pulse; DONE to IDLE.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is idle: bus_req, dack, bus_rd, bus_wr, bus_word, tc_end and ch_active are 0 and bus_addr is 0.
- R2: A cfg_load pulse while idle with cfg_count nonzero arms the channel (ch_active becomes 1); with cfg_count zero the channel stays idle.
- R3: A bus cycle is T1 (address only, no strobe), then T2 and T3 with the strobe high, so 3 clocks with ready high; every clock of T3 with bus_rdy low adds one clock, and bus_addr stays unchanged while the strobe is high.
- R4: An accepted request raises bus_req; T1 starts only after bus_gnt is seen high; dack is high exactly in the clocks of the channel's bus cycles and never without bus_req.
- R5: Single mode (cfg_mode = 0): each request gives exactly one transfer, then the channel waits for another request.
- R6: Demand mode (cfg_mode = 1): if the request is high at the end of a transfer, the next transfer's T1 follows with no idle clock; otherwise the channel waits.
- R7: Single-step mode (cfg_mode = 2): after each transfer bus_req drops, and the next transfer starts only after a cpu_done pulse, which raises bus_req again.
- R8: Burst mode (cfg_mode = 3): each request gives cfg_burst + 1 transfers back to back, cut short only by the count expiring.
- R9: With cfg_m2m = 0 a transfer is one bus cycle at the source address, with the read strobe when cfg_memrd = 1 and the write strobe when cfg_memrd = 0; with cfg_m2m = 1 it is a read at the source address followed by a write at the destination address. bus_rd and bus_wr are never high together.
- R10: After each transfer the address (both addresses for a copy) changes by cfg_step: 0 or 3 fixed, 1 increment, 2 decrement, by 1 for bytes (cfg_word = 0) or 2 for words (cfg_word = 1), modulo 2^24; bus_word shows the size during bus cycles.
- R11: The count drops by one per transfer; after the transfer that brings it to zero, tc_end is high for exactly one clock and the channel returns to idle, ignoring further requests.
- R12: req_ext, req_per and req_sw are equivalent request sources; any one of them is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load configuration (accepted only when idle) |
| cfg_addr | input | 24 | Source / memory start address |
| cfg_dst | input | 24 | Destination start address for copies |
| cfg_count | input | 21 | Number of transfers |
| cfg_mode | input | 2 | 0 single, 1 demand, 2 single-step, 3 burst |
| cfg_word | input | 1 | 1 word, 0 byte |
| cfg_step | input | 2 | 0/3 fixed, 1 increment, 2 decrement |
| cfg_m2m | input | 1 | 1 memory-to-memory copy |
| cfg_memrd | input | 1 | One-cycle transfers: 1 memory read, 0 memory write |
| cfg_burst | input | 4 | Burst length minus one |
| req_ext | input | 1 | Request from the external pin |
| req_per | input | 1 | Request from an on-chip peripheral |
| req_sw | input | 1 | Software request |
| bus_gnt | input | 1 | Bus grant |
| cpu_done | input | 1 | Processor bus cycle completed (single-step) |
| bus_rdy | input | 1 | Ready, sampled in T3 |
| bus_req | output | 1 | Bus request |
| dack | output | 1 | Acknowledge, high during DMA bus cycles |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | Word-size cycle |
| tc_end | output | 1 | Transfer-end pulse |
| ch_active | output | 1 | Channel enabled |

## Verification
Each request policy is driven with a request shape that separates it from the others: a single pulse in single mode must yield exactly one transfer, a request held over several transfers in demand mode must yield an unbroken run of acknowledge clocks, single-step mode must stall with the bus released until a processor-done pulse, and burst mode must produce the programmed run and then be cut by count expiry. A ready held low separates a correct wait-state stretch from a fixed-length cycle, and a decrement from address 1 in word size shows the wrap. Random single-mode runs with random addresses, step modes, sizes, request sources and ready patterns compare every bus address against a computed sequence.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_DEMAND = 2'd1,
        XM_STEP   = 2'd2,
        XM_BURST  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        AS_FIXED = 2'd0,
        AS_INC   = 2'd1,
        AS_DEC   = 2'd2,
        AS_HOLD  = 2'd3
    } addr_step_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_BUSREQ,
        S_T1,
        S_T2,
        S_T3,
        S_CPU,
        S_DONE
    } ch_state_e;

    typedef struct packed {
        xfer_mode_e mode;
        addr_step_e step;
        logic       word;
        logic       m2m;
        logic       memrd;
    } ch_cfg_t;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  addr_step_e    step,
    input  logic          word,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] delta;

    always_comb begin
        delta = {{(AW-2){1'b0}}, word, ~word};
        unique case (step)
            AS_INC:  nxt = cur + delta;
            AS_DEC:  nxt = cur - delta;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/dma_downcnt.sv
module dma_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= ld_val;
        else if (dec)
            cnt <= cnt - W'(1);
    end

    // R11: the counter is never stepped below zero
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 21,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_word,
    input  logic [1:0]    cfg_step,
    input  logic          cfg_m2m,
    input  logic          cfg_memrd,
    input  logic [BW-1:0] cfg_burst,
    input  logic          req_ext,
    input  logic          req_per,
    input  logic          req_sw,
    input  logic          bus_gnt,
    input  logic          cpu_done,
    input  logic          bus_rdy,
    output logic          bus_req,
    output logic          dack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_word,
    output logic          tc_end,
    output logic          ch_active
);
    localparam int NPTR = 2;

    ch_state_e     state, state_nx;
    ch_cfg_t       cfg_q;
    logic [BW-1:0] burst_q;
    logic          phase_q;
    logic [AW-1:0] ptr_q  [NPTR];
    logic [AW-1:0] ptr_nx [NPTR];
    logic [CW-1:0] tc_cnt;
    logic [BW-1:0] bc_cnt;

    logic req_any, xfer_end, tc_last, burst_more, load_ok, in_bus, strobe, wr_phase;

    assign req_any    = req_ext | req_per | req_sw;
    assign load_ok    = (state == S_IDLE) && cfg_load;
    assign xfer_end   = (state == S_T3) && bus_rdy && (!cfg_q.m2m || phase_q);
    assign tc_last    = (tc_cnt == CW'(1));
    assign burst_more = xfer_end && (cfg_q.mode == XM_BURST) && !tc_last && (bc_cnt != '0);

    dma_downcnt #(.W(CW)) u_tc (
        .clk(clk), .rst_n(rst_n), .load(load_ok), .ld_val(cfg_count),
        .dec(xfer_end), .cnt(tc_cnt)
    );

    dma_downcnt #(.W(BW)) u_bc (
        .clk(clk), .rst_n(rst_n), .load((state == S_ARMED) && req_any),
        .ld_val(burst_q), .dec(burst_more), .cnt(bc_cnt)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_addr_step #(.AW(AW)) u_step (
            .cur(ptr_q[g]), .step(cfg_q.step), .word(cfg_q.word), .nxt(ptr_nx[g])
        );
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (cfg_load && (cfg_count != '0)) state_nx = S_ARMED;
            S_ARMED:  if (req_any) state_nx = S_BUSREQ;
            S_BUSREQ: if (bus_gnt) state_nx = S_T1;
            S_T1:     state_nx = S_T2;
            S_T2:     state_nx = S_T3;
            S_T3: begin
                if (!bus_rdy)
                    state_nx = S_T3;
                else if (!xfer_end)
                    state_nx = S_T1;
                else if (tc_last)
                    state_nx = S_DONE;
                else begin
                    unique case (cfg_q.mode)
                        XM_SINGLE: state_nx = S_ARMED;
                        XM_DEMAND: state_nx = req_any ? S_T1 : S_ARMED;
                        XM_STEP:   state_nx = S_CPU;
                        XM_BURST:  state_nx = burst_more ? S_T1 : S_ARMED;
                        default:   state_nx = S_ARMED;
                    endcase
                end
            end
            S_CPU:    if (cpu_done) state_nx = S_BUSREQ;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // configuration, phase and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            burst_q  <= '0;
            phase_q  <= 1'b0;
            ptr_q[0] <= '0;
            ptr_q[1] <= '0;
        end else begin
            if (load_ok) begin
                cfg_q    <= '{mode: xfer_mode_e'(cfg_mode), step: addr_step_e'(cfg_step),
                              word: cfg_word, m2m: cfg_m2m, memrd: cfg_memrd};
                burst_q  <= cfg_burst;
                phase_q  <= 1'b0;
                ptr_q[0] <= cfg_addr;
                ptr_q[1] <= cfg_dst;
            end
            if ((state == S_T3) && bus_rdy)
                phase_q <= cfg_q.m2m && !phase_q;
            if (xfer_end) begin
                ptr_q[0] <= ptr_nx[0];
                if (cfg_q.m2m) ptr_q[1] <= ptr_nx[1];
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        in_bus    = (state == S_T1) || (state == S_T2) || (state == S_T3);
        strobe    = (state == S_T2) || (state == S_T3);
        wr_phase  = cfg_q.m2m ? phase_q : !cfg_q.memrd;
        bus_req   = in_bus || (state == S_BUSREQ);
        dack      = in_bus;
        bus_addr  = in_bus ? (phase_q ? ptr_q[1] : ptr_q[0]) : '0;
        bus_rd    = strobe && !wr_phase;
        bus_wr    = strobe && wr_phase;
        bus_word  = in_bus && cfg_q.word;
        tc_end    = (state == S_DONE);
        ch_active = (state != S_IDLE) && (state != S_DONE);
    end

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_dack_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> bus_req);

    p_wait_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_T3) && !bus_rdy) |=> ((state == S_T3) && $stable(bus_addr)));

    p_addr_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_T1) |=> (state == S_T2));

    p_end_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tc_end |=> (!tc_end && !ch_active));

    p_step_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && (cfg_q.mode == XM_STEP) && !tc_last) |=> !bus_req);
endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 0, cfg_word = 0, cfg_m2m = 0, cfg_memrd = 0;
    logic [23:0] cfg_addr = '0, cfg_dst = '0;
    logic [20:0] cfg_count = '0;
    logic [1:0]  cfg_mode = '0, cfg_step = '0;
    logic [3:0]  cfg_burst = '0;
    logic        req_ext = 0, req_per = 0, req_sw = 0;
    logic        bus_gnt = 1, cpu_done = 0, bus_rdy = 1;
    logic        bus_req, dack, bus_rd, bus_wr, bus_word, tc_end, ch_active;
    logic [23:0] bus_addr;

    int checks = 0, fails = 0;
    bit finished = 0;

    dma_chan u_dma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
        .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_mode(cfg_mode),
        .cfg_word(cfg_word), .cfg_step(cfg_step), .cfg_m2m(cfg_m2m),
        .cfg_memrd(cfg_memrd), .cfg_burst(cfg_burst), .req_ext(req_ext),
        .req_per(req_per), .req_sw(req_sw), .bus_gnt(bus_gnt),
        .cpu_done(cpu_done), .bus_rdy(bus_rdy), .bus_req(bus_req), .dack(dack),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .tc_end(tc_end), .ch_active(ch_active)
    );

    always #(CLK_P/2) clk = ~clk;

    // bus monitor, sampled on the falling edge
    logic [23:0] log_addr [64];
    logic        log_wr   [64];
    int n_log = 0, cur_len = 0, last_len = 0, dack_cnt = 0, tc_cnt = 0, addr_jump = 0;
    logic prev_strobe = 0;
    logic [23:0] prev_addr = '0;
    wire strobe = bus_rd | bus_wr;

    always @(negedge clk) begin
        if (strobe) begin
            cur_len++;
            if (prev_strobe && bus_addr != prev_addr) addr_jump++;
        end
        if (strobe && !prev_strobe) begin
            log_addr[n_log % 64] = bus_addr;
            log_wr[n_log % 64]   = bus_wr;
            n_log++;
        end
        if (!strobe && prev_strobe) begin
            last_len = cur_len;
            cur_len  = 0;
        end
        if (dack) dack_cnt++;
        if (tc_end) tc_cnt++;
        prev_strobe = strobe;
        prev_addr   = bus_addr;
    end

    function automatic logic [23:0] exp_addr(logic [23:0] base, logic [1:0] stp,
                                             logic wd, int k);
        logic [23:0] d = wd ? 24'd2 : 24'd1;
        if (stp == 2'd1) return base + d * 24'(k);
        if (stp == 2'd2) return base - d * 24'(k);
        return base;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 0;
        req_ext = 0; req_per = 0; req_sw = 0; cpu_done = 0; bus_rdy = 1; bus_gnt = 1;
        idle(2);
        rst_n = 1;
    endtask

    task automatic load(logic [23:0] a, logic [23:0] d, logic [20:0] c, logic [1:0] m,
                        logic wd, logic [1:0] stp, logic mm, logic mr, logic [3:0] b);
        @(posedge clk); #1;
        cfg_addr = a; cfg_dst = d; cfg_count = c; cfg_mode = m; cfg_word = wd;
        cfg_step = stp; cfg_m2m = mm; cfg_memrd = mr; cfg_burst = b; cfg_load = 1;
        @(posedge clk); #1 cfg_load = 0;
    endtask

    task automatic pulse(int src);
        @(posedge clk); #1;
        if (src == 0) req_ext = 1; else if (src == 1) req_per = 1; else req_sw = 1;
        @(posedge clk); #1;
        req_ext = 0; req_per = 0; req_sw = 0;
    endtask

    task automatic cpu_pulse();
        @(posedge clk); #1 cpu_done = 1;
        @(posedge clk); #1 cpu_done = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int b, d0, t0;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);

        // R1: reset state
        idle(1);
        check(!bus_req && !dack && !bus_rd && !bus_wr && !bus_word && !tc_end && !ch_active
              && bus_addr == 0, "R1 outputs in reset", {bus_req, dack, ch_active}, 0);
        idle(2); rst_n = 1; idle(1);
        check(!bus_req && !ch_active && bus_addr == 0, "R1 outputs after reset",
              {bus_req, ch_active}, 0);

        // R2: zero count stays idle, nonzero count arms
        load(24'h10, 0, 0, 2'd0, 0, 2'd1, 0, 1, 0);
        check(!ch_active, "R2 zero count stays idle", ch_active, 0);
        load(24'h10, 0, 3, 2'd0, 0, 2'd1, 0, 1, 0);
        check(ch_active, "R2 nonzero count arms", ch_active, 1);

        // R5, R12, R4, R3, R9, R10, R11: single mode with each source
        b = n_log; d0 = dack_cnt; t0 = tc_cnt;
        pulse(0); idle(10);
        check(n_log - b == 1, "R5 one transfer per request", n_log - b, 1);
        check(log_addr[b % 64] == 24'h10 && !log_wr[b % 64], "R9 memory read at source",
              log_addr[b % 64], 24'h10);
        check(dack_cnt - d0 == 3, "R4 dack spans one bus cycle", dack_cnt - d0, 3);
        check(last_len == 2, "R3 strobe length without wait", last_len, 2);
        pulse(1); idle(10);
        check(n_log - b == 2 && log_addr[(b + 1) % 64] == 24'h11,
              "R12 peripheral request and R10 byte increment", log_addr[(b + 1) % 64], 24'h11);
        pulse(2); idle(10);
        check(n_log - b == 3 && tc_cnt - t0 == 1, "R11 end pulse once", tc_cnt - t0, 1);
        check(!ch_active, "R11 channel disabled at count end", ch_active, 0);
        pulse(0); idle(10);
        check(n_log - b == 3, "R11 request ignored after end", n_log - b, 3);

        // R4: grant withheld
        do_reset();
        load(24'h20, 0, 2, 2'd0, 0, 2'd1, 0, 1, 0);
        bus_gnt = 0; b = n_log;
        pulse(0); idle(6);
        check(bus_req && !dack && n_log == b, "R4 waits for grant", {bus_req, dack}, 2'b10);
        bus_gnt = 1; idle(6);
        check(n_log - b == 1, "R4 cycle after grant", n_log - b, 1);

        // R6, R10 wrap, R9 write: demand mode
        do_reset();
        load(24'h000001, 0, 10, 2'd1, 1, 2'd2, 0, 0, 0);
        b = n_log; d0 = dack_cnt;
        @(posedge clk); #1 req_ext = 1;
        repeat (10) @(posedge clk);
        #1 req_ext = 0;
        idle(10);
        check(n_log - b == 3, "R6 transfers while request held", n_log - b, 3);
        check(dack_cnt - d0 == 9, "R6 back to back cycles", dack_cnt - d0, 9);
        check(log_addr[(b + 1) % 64] == 24'hFFFFFF && log_addr[(b + 2) % 64] == 24'hFFFFFD,
              "R10 word decrement wraps", log_addr[(b + 1) % 64], 24'hFFFFFF);
        check(log_wr[b % 64] && bus_word == 0 && ch_active, "R9 memory write one cycle",
              log_wr[b % 64], 1);

        // R7: single-step mode
        do_reset();
        load(24'h40, 0, 3, 2'd2, 0, 2'd1, 0, 1, 0);
        b = n_log; t0 = tc_cnt;
        pulse(2); idle(15);
        check(n_log - b == 1 && !bus_req, "R7 bus released after transfer", n_log - b, 1);
        cpu_pulse(); idle(10);
        check(n_log - b == 2 && !bus_req, "R7 next transfer after cpu_done", n_log - b, 2);
        cpu_pulse(); idle(10);
        check(n_log - b == 3 && tc_cnt - t0 == 1 && !ch_active, "R7 completes with R11 end",
              n_log - b, 3);

        // R8, R9 copy, R11 mid-burst end: burst mode
        do_reset();
        load(24'h100, 24'h200, 5, 2'd3, 1, 2'd1, 1, 0, 4'd2);
        b = n_log; t0 = tc_cnt;
        pulse(1); idle(30);
        check(n_log - b == 6, "R8 burst of three copies", n_log - b, 6);
        for (int k = 0; k < 3; k++) begin
            check(log_addr[(b + 2*k) % 64] == 24'h100 + 24'(2*k) && !log_wr[(b + 2*k) % 64],
                  "R9 copy read at source", log_addr[(b + 2*k) % 64], 24'h100 + 2*k);
            check(log_addr[(b + 2*k + 1) % 64] == 24'h200 + 24'(2*k) && log_wr[(b + 2*k + 1) % 64],
                  "R9 copy write at destination", log_addr[(b + 2*k + 1) % 64], 24'h200 + 2*k);
        end
        check(ch_active && tc_cnt == t0, "R8 waits after burst", ch_active, 1);
        pulse(0); idle(30);
        check(n_log - b == 10 && tc_cnt - t0 == 1 && !ch_active, "R11 count cuts burst",
              n_log - b, 10);

        // R3: wait states, R10 fixed address
        do_reset();
        load(24'h55, 0, 3, 2'd0, 0, 2'd0, 0, 1, 0);
        bus_rdy = 0; b = n_log; addr_jump = 0;
        pulse(0);
        repeat (8) @(posedge clk);
        #1 bus_rdy = 1;
        idle(5);
        check(last_len == 7, "R3 five wait clocks stretch strobe", last_len, 7);
        check(addr_jump == 0, "R3 address stable under strobe", addr_jump, 0);
        d0 = dack_cnt;
        pulse(1); idle(8);
        check(last_len == 2 && dack_cnt - d0 == 3, "R3 no-wait cycle is three clocks",
              dack_cnt - d0, 3);
        check(log_addr[(b + 1) % 64] == 24'h55, "R10 fixed address", log_addr[(b + 1) % 64], 24'h55);

        // random single-mode runs
        for (int it = 0; it < 6; it++) begin
            logic [23:0] a0;
            logic [1:0]  stp;
            logic        wd;
            int          cnt;
            do_reset();
            a0 = 24'($urandom); stp = 2'($urandom); wd = 1'($urandom);
            cnt = 1 + int'($urandom % 4);
            load(a0, 0, 21'(cnt), 2'd0, wd, stp, 0, 1'($urandom), 0);
            b = n_log; t0 = tc_cnt;
            for (int r = 0; r < cnt; r++) begin
                pulse(int'($urandom % 3));
                for (int c = 0; c < 12; c++) begin
                    bus_rdy = 1'($urandom);
                    idle(1);
                end
                bus_rdy = 1;
                idle(8);
            end
            for (int k = 0; k < cnt; k++)
                check(log_addr[(b + k) % 64] == exp_addr(a0, stp, wd, k), "R10 random address",
                      log_addr[(b + k) % 64], exp_addr(a0, stp, wd, k));
            check(n_log - b == cnt && tc_cnt - t0 == 1 && !ch_active, "R11 random run end",
                  n_log - b, cnt);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule